// File: doc/BRIEF.md
# Sequential Combination Lock

This block is a clocked door lock. A user enters three values one at a time, each marked by a one-cycle strobe. The door opens only when all three match a fixed combination, in the stored order. The design splits into two parts:

- **Datapath:** three stored combination values, a one-hot selector that picks one of them, and a single equality comparator.
- **Controller:** a five-state machine that advances on each matching entry and falls into a latched error state on the first mismatch.

Both the open state and the error state persist until a synchronous reset returns the lock to its first waiting state. The state register uses a 4-bit encoding that was chosen so the outputs need no decoding. Its low three bits are the selector, and its top bit is the door output.

Top module: `combo_lock`

## Requirements
- R1: While `rst` is high at a clock edge, the state becomes WAIT1 (code 4'b0001), and the next cycle shows `door_open`=0 and `sel_onehot`=3'b001. Reset takes priority over a strobe in the same cycle.
- R2: In WAIT1, WAIT2 or WAIT3, a cycle with `strobe`=0 leaves the state unchanged, whatever value is on `key_in`.
- R3: A strobe whose `key_in` equals the selected combination value advances the state: WAIT1 (0001) to WAIT2 (0010), WAIT2 to WAIT3 (0100), and WAIT3 to UNLOCKED (1000).
- R4: A strobe in WAIT1, WAIT2 or WAIT3 whose `key_in` differs from the selected value moves the state to FAULT (0000).
- R5: UNLOCKED and FAULT hold, whatever `strobe` and `key_in` do, until `rst` is asserted.
- R6: `sel_onehot` equals `state_code[2:0]`. It is 001, 010 or 100 in WAIT1, WAIT2 or WAIT3, selecting combination values 1, 2 and 3, and it is 000 in UNLOCKED and FAULT.
- R7: `door_open` equals `state_code[3]`. It is 1 only in UNLOCKED.
- R8: The default combination is 3, 4, 2, set by parameters. Values are 4 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | One-cycle pulse marking a new entry |
| key_in | input | 4 | Entered value, valid while strobe is high |
| state_code | output | 4 | Current state register |
| sel_onehot | output | 3 | One-hot combination select |
| door_open | output | 1 | 1 = door open |

## Verification
Two events can fall in the same cycle: a reset and a value strobe. The bench provokes this both with a matching key and with a mismatching key, in WAIT states and in the latched states. It judges the outcome by requiring that the state is WAIT1 one edge later. Random sequences mix near-miss keys, idle gaps and rare resets. After every edge the bench compares all outputs with a reference model written in the bench.

// File: rtl/combo_lock_pkg.sv
package combo_lock_pkg;
    localparam int KEY_W   = 4;
    localparam int N_STEPS = 3;
    localparam int ST_W    = N_STEPS + 1;

    typedef enum logic [ST_W-1:0] {
        ST_WAIT1    = 4'b0001,
        ST_WAIT2    = 4'b0010,
        ST_WAIT3    = 4'b0100,
        ST_UNLOCKED = 4'b1000,
        ST_FAULT    = 4'b0000
    } lock_state_e;

    typedef struct packed {
        logic                 open;
        logic [N_STEPS-1:0]   sel;
    } lock_out_s;

    function automatic lock_out_s split_state(input lock_state_e s);
        lock_out_s o;
        o.open = s[ST_W-1];
        o.sel  = s[N_STEPS-1:0];
        return o;
    endfunction
endpackage

// File: rtl/combo_store.sv
module combo_store
    import combo_lock_pkg::*;
#(
    parameter logic [KEY_W-1:0] CODE0 = 4'd3,
    parameter logic [KEY_W-1:0] CODE1 = 4'd4,
    parameter logic [KEY_W-1:0] CODE2 = 4'd2
) (
    input  logic [N_STEPS-1:0] sel,
    output logic [KEY_W-1:0]   picked
);
    logic [KEY_W-1:0] codes [N_STEPS];
    assign codes[0] = CODE0;
    assign codes[1] = CODE1;
    assign codes[2] = CODE2;

    always_comb begin
        picked = '0;
        for (int i = 0; i < N_STEPS; i++) begin
            if (sel[i]) picked = picked | codes[i];
        end
    end
endmodule

// File: rtl/key_compare.sv
module key_compare
    import combo_lock_pkg::*;
(
    input  logic [KEY_W-1:0] a,
    input  logic [KEY_W-1:0] b,
    output logic             equal
);
    assign equal = (a == b);
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
    import combo_lock_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        strobe,
    input  logic        equal,
    output lock_state_e state
);
    lock_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_WAIT1:    if (strobe) nxt = equal ? ST_WAIT2    : ST_FAULT;
            ST_WAIT2:    if (strobe) nxt = equal ? ST_WAIT3    : ST_FAULT;
            ST_WAIT3:    if (strobe) nxt = equal ? ST_UNLOCKED : ST_FAULT;
            ST_UNLOCKED: nxt = ST_UNLOCKED;
            ST_FAULT:    nxt = ST_FAULT;
            default:     nxt = ST_FAULT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_WAIT1;
        else     state <= nxt;
    end

    a_r1_reset_to_wait1: assert property (@(posedge clk)
        rst |=> state == ST_WAIT1);
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!strobe && state inside {ST_WAIT1, ST_WAIT2, ST_WAIT3}) |=> $stable(state));
    a_r4_mismatch_faults: assert property (@(posedge clk) disable iff (rst)
        (strobe && !equal && state inside {ST_WAIT1, ST_WAIT2, ST_WAIT3}) |=> state == ST_FAULT);
    a_r5_final_holds: assert property (@(posedge clk) disable iff (rst)
        (state inside {ST_UNLOCKED, ST_FAULT}) |=> $stable(state));
endmodule

// File: rtl/combo_lock.sv
module combo_lock
    import combo_lock_pkg::*;
#(
    parameter logic [KEY_W-1:0] CODE0 = 4'd3,
    parameter logic [KEY_W-1:0] CODE1 = 4'd4,
    parameter logic [KEY_W-1:0] CODE2 = 4'd2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic [KEY_W-1:0] key_in,
    output logic [ST_W-1:0]  state_code,
    output logic [N_STEPS-1:0] sel_onehot,
    output logic             door_open
);
    lock_state_e      state;
    lock_out_s        outs;
    logic [KEY_W-1:0] picked;
    logic             equal;

    combo_store #(.CODE0(CODE0), .CODE1(CODE1), .CODE2(CODE2)) u_store (
        .sel    (outs.sel),
        .picked (picked)
    );

    key_compare u_cmp (
        .a     (key_in),
        .b     (picked),
        .equal (equal)
    );

    lock_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .strobe (strobe),
        .equal  (equal),
        .state  (state)
    );

    assign outs       = split_state(state);
    assign state_code = state;
    assign sel_onehot = outs.sel;
    assign door_open  = outs.open;

    a_r6_sel_onehot0: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_onehot) && (door_open -> sel_onehot == '0));
    a_r7_open_only_after_wait3: assert property (@(posedge clk) disable iff (rst)
        $rose(door_open) |-> $past(sel_onehot) == 3'b100 && $past(strobe));
    a_r3_match_leaves_wait1: assert property (@(posedge clk) disable iff (rst)
        (strobe && sel_onehot == 3'b001 && key_in == CODE0) |=> sel_onehot == 3'b010);
endmodule

// File: tb/combo_lock_bench.sv
module combo_lock_bench;
    logic       clk = 0;
    logic       rst, strobe;
    logic [3:0] key_in;
    logic [3:0] state_code;
    logic [2:0] sel_onehot;
    logic       door_open;
    int         n_chk = 0, n_fail = 0;
    logic [3:0] exp_st;
    bit         done = 0;

    always #2 clk = ~clk;

    combo_lock u_combo_lock (.clk(clk), .rst(rst), .strobe(strobe), .key_in(key_in),
        .state_code(state_code), .sel_onehot(sel_onehot), .door_open(door_open));

    function automatic logic [3:0] code_of(input logic [3:0] st);
        case (st)
            4'b0001: return 4'd3;
            4'b0010: return 4'd4;
            default: return 4'd2;
        endcase
    endfunction

    function automatic logic [3:0] model_next(input logic [3:0] st, input logic r,
                                              input logic s, input logic [3:0] k);
        if (r) return 4'b0001;
        if (st == 4'b1000 || st == 4'b0000) return st;
        if (!s) return st;
        if (k != code_of(st)) return 4'b0000;
        case (st)
            4'b0001: return 4'b0010;
            4'b0010: return 4'b0100;
            default: return 4'b1000;
        endcase
    endfunction

    task automatic check(input string req);
        n_chk++;
        if (state_code !== exp_st) begin
            n_fail++;
            $display("FAIL %s state act=%b exp=%b", req, state_code, exp_st);
        end
        if (sel_onehot !== exp_st[2:0]) begin
            n_fail++;
            $display("FAIL R6 sel act=%b exp=%b", sel_onehot, exp_st[2:0]);
        end
        if (door_open !== exp_st[3]) begin
            n_fail++;
            $display("FAIL R7 door act=%b exp=%b", door_open, exp_st[3]);
        end
    endtask

    task automatic step(input logic r, input logic s, input logic [3:0] k, input string req);
        rst = r; strobe = s; key_in = k;
        exp_st = model_next(exp_st, r, s, k);
        @(posedge clk); #1;
        check(req);
    endtask

    initial begin
        rst = 1; strobe = 0; key_in = 0; exp_st = 4'b0001;
        @(posedge clk); #1;
        check("R1");
        // R8 / R3 correct combination 3,4,2
        step(0, 1, 4'd3, "R3");
        step(0, 0, 4'd9, "R2");
        step(0, 1, 4'd4, "R3");
        step(0, 1, 4'd2, "R8");
        step(0, 1, 4'd7, "R5");
        step(0, 0, 4'd0, "R5");
        step(1, 0, 4'd0, "R1");
        // R4 mismatch at each position
        step(0, 1, 4'd2, "R4");
        step(0, 1, 4'd3, "R5");
        step(1, 0, 4'd0, "R1");
        step(0, 1, 4'd3, "R3");
        step(0, 1, 4'd3, "R4");
        step(1, 0, 4'd0, "R1");
        step(0, 1, 4'd3, "R3");
        step(0, 1, 4'd4, "R3");
        step(0, 1, 4'd4, "R4");
        // reset colliding with strobe
        step(1, 1, 4'd3, "R1");
        step(0, 1, 4'd3, "R3");
        step(1, 1, 4'd4, "R1");
        step(1, 1, 4'd9, "R1");
        // random
        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            logic r, s;
            logic [3:0] k;
            r = ($urandom % 20) == 0;
            s = ($urandom % 3) != 0;
            k = ($urandom % 4 != 0) ? code_of(exp_st) : 4'($urandom);
            step(r, s, k, "R2");
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=hung exp=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule